// File: doc/BRIEF.md
# Logic analyzer trigger comparator

This block watches a probe bus and decides, once per sample clock, whether a programmed trigger condition holds. The condition has two parts. Each probe bit carries a three-bit code. The code asks for a level (low or high), an edge (rising, falling or either), the absence of an edge, or nothing at all. On top of that, a word-level operator compares the whole probe word. It can test equality or inequality of the per-bit pattern, the order between the probe word and one operand, or whether the word lies inside or outside a window set by two operands.

Edge codes compare each bit against the sample taken on the previous clock. A small state machine records whether that previous sample exists. It has two states. `ST_PRIME` is entered on reset, when there is no history yet. `ST_TRACK` is used once a sample has been stored. The transition `first_sample` goes from `ST_PRIME` to `ST_TRACK` on the first clock after reset. The machine then stays in `ST_TRACK` (transition `keep_tracking`) until the next reset.

The result is registered, so `match_o` is a per-sample flag that appears one clock after the sample it describes. A build-time parameter selects how much comparison hardware exists:
- basic: equal and not-equal only
- extended: adds the ordering operators
- range: adds the window tests

Configuration is expected to stay stable while the trigger is in use.

Top module: `trig_comparator`

## Requirements
- R1: While `rst_n` is low, `match_o` is 0. It stays 0 until the first sample after reset has been evaluated.
- R2: Code 0 requires the probe bit to be 0, and code 1 requires it to be 1.
- R3: Codes 2 and 7 are don't-care. A bit with either code never changes the result of any operator and is removed from word comparisons.
- R4: Code 3 requires a rising edge (previous 0, current 1). Code 4 requires a falling edge (previous 1, current 0). Code 5 requires either edge.
- R5: Code 6 (no edge) requires the bit to equal its previous sample.
- R6: On the first sample after reset, every bit coded 3, 4, 5 or 6 fails, because there is no previous sample.
- R7: Operator 0 (equal) is true when every bit satisfies its code. Operator 1 (not-equal) is exactly its inverse. With every bit don't-care, equal is true and not-equal is false.
- R8: Operators 2 (greater than), 3 (greater or equal), 4 (less than) and 5 (less or equal) compare, unsigned, the probe word against `opa_i`. Both words have don't-care bits cleared first. Bits coded 3 to 6 must also satisfy their edge condition. Bits coded 0 and 1 only include the bit in the comparison.
- R9: Operator 6 (in range) is true when `opa_i` <= probe <= `opb_i`, with both bounds inclusive. Operator 7 (out of range) is its complement. Don't-care bits are cleared in all three words, and edge-coded bits must satisfy their edge condition, as in R8.
- R10: `match_o` changes only at a clock edge. It shows the result for the probe and configuration sampled at that edge.
- R11: Parameter `MODE` selects the hardware: 0 supports operators 0 and 1 only, 1 adds operators 2 to 5, and 2 adds operators 6 and 7. An operator that the build does not support always yields 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| probe_i | input | W | Probed signal bus |
| pattern_i | input | 3*W | Per-bit condition codes, bit i in [3i+2:3i] |
| op_i | input | 3 | Word-level operator select |
| opa_i | input | W | Compare operand, or low bound of the window |
| opb_i | input | W | High bound of the window |
| match_o | output | 1 | Registered trigger result |

## Verification
The hardest condition to reach from the ports is the first sample after reset, the only cycle in which edge and no-edge codes must fail regardless of the probe value. The bench reasserts reset in the middle of the run with a no-edge pattern and a probe held constant. It checks that the first sample does not match and that the next identical sample does. The edge-qualified ordering test is also hard to reach, because its result depends on the previous sample. The stimulus arranges the prior probe value on purpose, so that the same word fails with a falling bit and passes with a rising one.

// File: rtl/trig_pkg.sv
package trig_pkg;

    // Per-bit condition codes
    typedef enum logic [2:0] {
        PC_LOW    = 3'd0,
        PC_HIGH   = 3'd1,
        PC_DC     = 3'd2,
        PC_RISE   = 3'd3,
        PC_FALL   = 3'd4,
        PC_EITHER = 3'd5,
        PC_STEADY = 3'd6,
        PC_SPARE  = 3'd7
    } pcode_e;

    // Word-level operators
    typedef enum logic [2:0] {
        OP_EQ  = 3'd0,
        OP_NE  = 3'd1,
        OP_GT  = 3'd2,
        OP_GE  = 3'd3,
        OP_LT  = 3'd4,
        OP_LE  = 3'd5,
        OP_IN  = 3'd6,
        OP_OUT = 3'd7
    } cmp_op_e;

    // History tracker states
    typedef enum logic {
        ST_PRIME = 1'b0,
        ST_TRACK = 1'b1
    } hist_state_e;

    localparam int MODE_BASIC = 0;
    localparam int MODE_EXT   = 1;
    localparam int MODE_RANGE = 2;

    localparam int CODE_W = 3;

endpackage

// File: rtl/trig_bit_eval.sv
module trig_bit_eval
    import trig_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    input  logic              cur_i,
    input  logic              prev_i,
    input  logic              hist_ok_i,
    output logic              bit_ok_o,
    output logic              edge_ok_o,
    output logic              care_o
);

    logic is_edge_code;
    logic edge_term;

    always_comb begin
        bit_ok_o     = 1'b1;
        is_edge_code = 1'b0;
        care_o       = 1'b1;
        edge_term    = 1'b1;
        unique case (pcode_e'(code_i))
            PC_LOW:    bit_ok_o = ~cur_i;
            PC_HIGH:   bit_ok_o = cur_i;
            PC_DC:     care_o   = 1'b0;
            PC_RISE: begin
                is_edge_code = 1'b1;
                edge_term    = ~prev_i & cur_i;
                bit_ok_o     = hist_ok_i & edge_term;
            end
            PC_FALL: begin
                is_edge_code = 1'b1;
                edge_term    = prev_i & ~cur_i;
                bit_ok_o     = hist_ok_i & edge_term;
            end
            PC_EITHER: begin
                is_edge_code = 1'b1;
                edge_term    = prev_i ^ cur_i;
                bit_ok_o     = hist_ok_i & edge_term;
            end
            PC_STEADY: begin
                is_edge_code = 1'b1;
                edge_term    = ~(prev_i ^ cur_i);
                bit_ok_o     = hist_ok_i & edge_term;
            end
            PC_SPARE:  care_o   = 1'b0;
        endcase
        edge_ok_o = is_edge_code ? bit_ok_o : 1'b1;
    end

endmodule

// File: rtl/trig_word_cmp.sv
module trig_word_cmp
    import trig_pkg::*;
#(
    parameter int W    = 8,
    parameter int MODE = MODE_RANGE
) (
    input  logic [W-1:0] val_i,
    input  logic [W-1:0] lo_i,
    input  logic [W-1:0] hi_i,
    input  logic [2:0]   op_i,
    input  logic         bits_ok_i,
    input  logic         edges_ok_i,
    output logic         hit_o
);

    logic gt_a, ge_a, lt_a, le_a;
    logic in_win;

    generate
        if (MODE >= MODE_EXT) begin : g_order
            assign gt_a = val_i >  lo_i;
            assign ge_a = val_i >= lo_i;
            assign lt_a = val_i <  lo_i;
            assign le_a = val_i <= lo_i;
        end else begin : g_no_order
            assign gt_a = 1'b0;
            assign ge_a = 1'b0;
            assign lt_a = 1'b0;
            assign le_a = 1'b0;
        end

        if (MODE >= MODE_RANGE) begin : g_window
            logic above_lo, below_hi;
            assign above_lo = val_i >= lo_i;
            assign below_hi = val_i <= hi_i;
            assign in_win   = above_lo & below_hi;
        end else begin : g_no_window
            assign in_win = 1'b0;
        end
    endgenerate

    always_comb begin
        hit_o = 1'b0;
        unique case (cmp_op_e'(op_i))
            OP_EQ:  hit_o = bits_ok_i;
            OP_NE:  hit_o = ~bits_ok_i;
            OP_GT:  hit_o = (MODE >= MODE_EXT) && edges_ok_i && gt_a;
            OP_GE:  hit_o = (MODE >= MODE_EXT) && edges_ok_i && ge_a;
            OP_LT:  hit_o = (MODE >= MODE_EXT) && edges_ok_i && lt_a;
            OP_LE:  hit_o = (MODE >= MODE_EXT) && edges_ok_i && le_a;
            OP_IN:  hit_o = (MODE >= MODE_RANGE) && edges_ok_i && in_win;
            OP_OUT: hit_o = (MODE >= MODE_RANGE) && edges_ok_i && ~in_win;
        endcase
    end

endmodule

// File: rtl/trig_comparator.sv
module trig_comparator
    import trig_pkg::*;
#(
    parameter int W    = 8,
    parameter int MODE = MODE_RANGE
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [W-1:0]        probe_i,
    input  logic [CODE_W*W-1:0] pattern_i,
    input  logic [2:0]          op_i,
    input  logic [W-1:0]        opa_i,
    input  logic [W-1:0]        opb_i,
    output logic                match_o
);

    localparam int PAT_W = CODE_W * W;

    hist_state_e state_q, state_d;
    logic [W-1:0] prev_q;
    logic         hist_ok;

    logic [W-1:0] bit_ok, edge_ok, care;
    logic         all_bits_ok, all_edges_ok;
    logic [W-1:0] val_m, lo_m, hi_m;
    logic         hit;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_PRIME;
        else        state_q <= state_d;
    end

    // Next state: first_sample, keep_tracking
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PRIME: state_d = ST_TRACK;
            ST_TRACK: state_d = ST_TRACK;
        endcase
    end

    assign hist_ok = (state_q == ST_TRACK);

    // Per-bit evaluation
    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            trig_bit_eval u_eval (
                .code_i    (pattern_i[CODE_W*i +: CODE_W]),
                .cur_i     (probe_i[i]),
                .prev_i    (prev_q[i]),
                .hist_ok_i (hist_ok),
                .bit_ok_o  (bit_ok[i]),
                .edge_ok_o (edge_ok[i]),
                .care_o    (care[i])
            );
        end
    endgenerate

    assign all_bits_ok  = &bit_ok;
    assign all_edges_ok = &edge_ok;
    assign val_m = probe_i & care;
    assign lo_m  = opa_i   & care;
    assign hi_m  = opb_i   & care;

    trig_word_cmp #(.W(W), .MODE(MODE)) u_cmp (
        .val_i      (val_m),
        .lo_i       (lo_m),
        .hi_i       (hi_m),
        .op_i       (op_i),
        .bits_ok_i  (all_bits_ok),
        .edges_ok_i (all_edges_ok),
        .hit_o      (hit)
    );

    // Output and history registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            match_o <= 1'b0;
            prev_q  <= '0;
        end else begin
            match_o <= hit;
            prev_q  <= probe_i;
        end
    end

    logic unused_w;
    assign unused_w = ^PAT_W;

endmodule

// File: rtl/trig_comparator_chk.sv
module trig_comparator_chk
    import trig_pkg::*;
#(
    parameter int W    = 8,
    parameter int MODE = MODE_RANGE
) (
    input logic                clk,
    input logic                rst_n,
    input logic [CODE_W*W-1:0] pattern_i,
    input logic [2:0]          op_i,
    input logic [W-1:0]        opa_i,
    input logic [W-1:0]        opb_i,
    input logic                match_o
);

    logic all_x, all_level, any_edge;
    logic seen_q;

    always_comb begin
        all_x     = 1'b1;
        all_level = 1'b1;
        any_edge  = 1'b0;
        for (int i = 0; i < W; i++) begin
            logic [2:0] c;
            c = pattern_i[CODE_W*i +: CODE_W];
            if (!(c == 3'd2 || c == 3'd7)) all_x = 1'b0;
            if (!(c == 3'd0 || c == 3'd1)) all_level = 1'b0;
            if (c >= 3'd3 && c <= 3'd6) any_edge = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    always @(posedge clk) begin
        if (!rst_n) assert_reset_quiet_R1: assert (!match_o);
    end

    assert_all_x_eq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (all_x && op_i == 3'd0) |=> match_o);

    assert_all_x_ne_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (all_x && op_i == 3'd1) |=> !match_o);

    assert_first_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!seen_q && any_edge && op_i == 3'd0) |=> !match_o);

    assert_le_top_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (MODE >= 1 && all_level && op_i == 3'd5 && opa_i == '1) |=> match_o);

    assert_full_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (MODE >= 2 && all_level && op_i == 3'd6 && opa_i == '0 && opb_i == '1) |=> match_o);

    assert_order_absent_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (MODE == 0 && op_i >= 3'd2) |=> !match_o);

endmodule

bind trig_comparator trig_comparator_chk #(.W(W), .MODE(MODE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pattern_i (pattern_i),
    .op_i      (op_i),
    .opa_i     (opa_i),
    .opb_i     (opb_i),
    .match_o   (match_o)
);

// File: tb/tb_trig_comparator.sv
module tb_trig_comparator;

    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    localparam logic [2:0] C_LOW = 3'd0, C_HIGH = 3'd1, C_DC = 3'd2,
                           C_RISE = 3'd3, C_FALL = 3'd4, C_EITHER = 3'd5, C_STEADY = 3'd6;
    localparam logic [2:0] O_EQ = 3'd0, O_NE = 3'd1, O_GT = 3'd2, O_GE = 3'd3,
                           O_LT = 3'd4, O_LE = 3'd5, O_IN = 3'd6, O_OUT = 3'd7;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [W-1:0]   probe = '0;
    logic [3*W-1:0] pattern = '0;
    logic [2:0]     op = 3'd0;
    logic [W-1:0]   opa = '0;
    logic [W-1:0]   opb = '0;
    logic           match, match_basic;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trig_comparator #(.W(W), .MODE(2)) dut (
        .clk(clk), .rst_n(rst_n), .probe_i(probe), .pattern_i(pattern),
        .op_i(op), .opa_i(opa), .opb_i(opb), .match_o(match)
    );

    trig_comparator #(.W(W), .MODE(0)) dut_basic (
        .clk(clk), .rst_n(rst_n), .probe_i(probe), .pattern_i(pattern),
        .op_i(op), .opa_i(opa), .opb_i(opb), .match_o(match_basic)
    );

    function automatic logic [3*W-1:0] fill(input logic [2:0] c);
        logic [3*W-1:0] r;
        for (int i = 0; i < W; i++) r[3*i +: 3] = c;
        return r;
    endfunction

    task automatic check(input logic act, input logic exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic step(input logic [W-1:0] p, input logic exp, input string tag);
        @(negedge clk);
        probe = p;
        @(posedge clk);
        #1;
        check(match, exp, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        probe = '0;
        @(posedge clk);
        #1;
        check(match, 1'b0, "R1 match low in reset");
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_levels();
        pattern = fill(C_DC);
        pattern[3*7 +: 3] = C_HIGH;
        pattern[0 +: 3]   = C_LOW;
        op = O_EQ;
        step(8'h80, 1'b1, "R2 level match");
        step(8'hFE, 1'b1, "R3 dont-care bits ignored");
        step(8'h81, 1'b0, "R2 low bit violated");
        step(8'h00, 1'b0, "R2 high bit violated");
        // R10: output holds before the edge, updates after it
        @(negedge clk);
        probe = 8'h80;
        #1;
        check(match, 1'b0, "R10 unchanged before edge");
        @(posedge clk);
        #1;
        check(match, 1'b1, "R10 updated after edge");
        op = O_NE;
        step(8'h81, 1'b1, "R7 not-equal true");
        step(8'h80, 1'b0, "R7 not-equal false");
        pattern = fill(C_DC);
        pattern[3*4 +: 3] = 3'd7;
        op = O_EQ;
        step(8'h5A, 1'b1, "R7 all dont-care equal");
        op = O_NE;
        step(8'hA5, 1'b0, "R7 all dont-care not-equal");
    endtask

    task automatic t_edges();
        pattern = fill(C_DC);
        op = O_EQ;
        step(8'h00, 1'b1, "R3 prime");
        pattern[3*2 +: 3] = C_RISE;
        step(8'h04, 1'b1, "R4 rising seen");
        step(8'h04, 1'b0, "R4 rising held high");
        step(8'h00, 1'b0, "R4 falling not rising");
        pattern[3*2 +: 3] = C_FALL;
        step(8'h04, 1'b0, "R4 fall on rise");
        step(8'h00, 1'b1, "R4 falling seen");
        pattern[3*2 +: 3] = C_EITHER;
        step(8'h04, 1'b1, "R4 either rise");
        step(8'h04, 1'b0, "R4 either none");
        step(8'h00, 1'b1, "R4 either fall");
        pattern[3*2 +: 3] = C_STEADY;
        step(8'h00, 1'b1, "R5 steady low");
        step(8'h04, 1'b0, "R5 changed");
        step(8'h04, 1'b1, "R5 steady high");
    endtask

    task automatic t_first_sample();
        pattern = fill(C_DC);
        op = O_EQ;
        step(8'h00, 1'b1, "R1 precondition high");
        pattern[0 +: 3] = C_STEADY;
        do_reset();
        @(posedge clk);
        #1;
        check(match, 1'b0, "R6 no-edge fails on first sample");
        step(8'h00, 1'b1, "R6 no-edge matches on second sample");
    endtask

    task automatic t_order();
        pattern = fill(C_HIGH);
        opa = 8'h40;
        op = O_GT;
        step(8'h41, 1'b1, "R8 gt above");
        step(8'h40, 1'b0, "R8 gt equal");
        op = O_GE;
        step(8'h40, 1'b1, "R8 ge equal");
        step(8'h3F, 1'b0, "R8 ge below");
        op = O_LT;
        step(8'h3F, 1'b1, "R8 lt below");
        step(8'h40, 1'b0, "R8 lt equal");
        op = O_LE;
        step(8'h40, 1'b1, "R8 le equal");
        step(8'h41, 1'b0, "R8 le above");
        op = O_GT;
        opa = 8'h7F;
        step(8'h80, 1'b1, "R8 unsigned compare");
        pattern[3*7 +: 3] = C_DC;
        opa = 8'h10;
        step(8'h85, 1'b0, "R8 masked bit removed");
        step(8'h91, 1'b1, "R8 masked above");
        pattern[0 +: 3] = C_RISE;
        op = O_GE;
        opa = 8'h00;
        step(8'h90, 1'b0, "R8 edge qualifier fails");
        step(8'h91, 1'b1, "R8 edge qualifier holds");
    endtask

    task automatic t_range();
        pattern = fill(C_HIGH);
        opa = 8'h20;
        opb = 8'h30;
        op = O_IN;
        step(8'h20, 1'b1, "R9 low bound inclusive");
        step(8'h30, 1'b1, "R9 high bound inclusive");
        step(8'h1F, 1'b0, "R9 below window");
        step(8'h31, 1'b0, "R9 above window");
        step(8'h25, 1'b1, "R9 inside window");
        op = O_OUT;
        step(8'h1F, 1'b1, "R9 out below");
        step(8'h20, 1'b0, "R9 out at bound");
        step(8'h31, 1'b1, "R9 out above");
    endtask

    task automatic t_basic_mode();
        pattern = fill(C_HIGH);
        opa = 8'h00;
        op = O_GT;
        step(8'hFF, 1'b1, "R11 full build supports gt");
        check(match_basic, 1'b0, "R11 basic build rejects gt");
        op = O_IN;
        opb = 8'hFF;
        step(8'hFF, 1'b1, "R11 full build supports range");
        check(match_basic, 1'b0, "R11 basic build rejects range");
        op = O_EQ;
        step(8'hFF, 1'b1, "R11 full build equal");
        check(match_basic, 1'b1, "R11 basic build equal");
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #2;
        check(match, 1'b0, "R1 reset state");
        do_reset();
        t_levels();
        t_edges();
        t_first_sample();
        t_order();
        t_range();
        t_basic_mode();
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule